// File: doc/BRIEF.md
# Dual-Tone Keypad Signalling Generator

This block turns one dialled keypad digit into a two-frequency signalling burst. It runs from a 3.579545 MHz system clock. When a valid digit code arrives with a start strobe, the block latches the code. It picks one low-group frequency and one high-group frequency for that key. Each frequency comes from its own clock divider, which steps a 32-entry sine lookup.

The two table levels are weighted and summed into an unsigned sample code, which goes to an external D/A stage. Each burst is followed by a silent interval. The block raises `busy` from the accepted strobe until both the tone minimum and the silence minimum have run out. While `busy` is high, new strobes are dropped.

A select input can limit the burst to the low group only or the high group only. This is intended for line testing.

Top module: `dtg_top`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it goes low (asynchronous reset), `busy`, `tone_on` and `sample` are all 0.
- R2: A `start` sampled high while `busy` is 0 and `digit` is valid is accepted at that clock edge. `busy` and `tone_on` are both 1 in the following cycle.
- R3: The digit encoding is as follows. Codes 1..9 map to row (code-1)/3 and column (code-1)%3. Code 10 (star) maps to row 3, column 0. Code 0 maps to row 3, column 1. Code 11 (hash) maps to row 3, column 2.
- R4: The low group advances one sine step every 160, 146, 132 or 118 clocks for rows 0..3, with 32 steps per period. Both phases are 0 in the first tone cycle. In the k-th cycle after acceptance (k from 0), the low phase is (k / divider) mod 32.
- R5: The high group follows the same rule with 92, 84 or 76 clocks per step for columns 0..2.
- R6: The sine level for phase p is defined as follows. Let m = p mod 16 and j = min(m, 16-m). Let q(j) for j = 0..8 be 0,1,2,4,5,6,6,7,7. The level is 8+q(j) when p < 16 and 7-q(j) otherwise. In dual mode, `sample` = 4 x low level + 5 x high level.
- R7: `tone_sel` 01 gives `sample` = 4 x low level. `tone_sel` 10 gives `sample` = 5 x high level. Values 00 and 11 give the dual sum.
- R8: `tone_on` stays high for exactly TONE_CYC cycles. Then `busy` stays high with `tone_on` low for exactly GAP_CYC cycles, and after that `busy` returns to 0.
- R9: A `start` sampled while `busy` is 1 is ignored. It neither restarts nor lengthens the burst or the gap.
- R10: Codes 12..15 are ignored. A strobe carrying one of them leaves `busy` at 0.
- R11: `sample` is 0 whenever `tone_on` is 0, including during the gap.
- R12: `digit` and `tone_sel` are captured at acceptance. Changing them during a burst does not alter the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a burst for `digit` |
| digit | input | 4 | Key code, 0..11 valid |
| tone_sel | input | 2 | 01 low only, 10 high only, otherwise both groups |
| busy | output | 1 | High from acceptance until the gap minimum ends |
| tone_on | output | 1 | High while the burst is audible |
| sample | output | 8 | Weighted sum of the sine levels, unsigned |

## Verification
The assertions check the following on every cycle:
- `sample` is silent outside the tone.
- An accepted strobe raises both flags.
- An invalid code never sets `busy`.
- Divider steps occur only during a tone.
- The exact tone and gap lengths are measured by counters in the checker. Any restart caused by a strobe during `busy` would show up as a wrong length.

Only the bench scenarios can show the following:
- The correct frequency pair for each of the twelve keys.
- The sine shape and weighting.
- The single-group modes.
- That inputs changed during a burst leave the waveform untouched.

The bench compares every cycle of every burst against its own model of phases and levels.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  localparam int PHASE_W   = 5;
  localparam int LEVEL_W   = 4;
  localparam int DIV_W     = 8;
  localparam int LO_WEIGHT = 4;
  localparam int HI_WEIGHT = 5;
  localparam int SAMPLE_W  = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TONE = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    MIX_BOTH  = 2'b00,
    MIX_LOW   = 2'b01,
    MIX_HIGH  = 2'b10,
    MIX_BOTHB = 2'b11
  } mix_t;

  typedef struct packed {
    logic       valid;
    logic [1:0] row;
    logic [1:0] col;
  } key_pos_t;

  // Keypad code to grid position; codes above 11 are invalid
  function automatic key_pos_t key_lookup(input logic [3:0] code);
    key_pos_t   kp;
    logic [3:0] m;
    m        = code - 4'd1;
    kp.valid = 1'b1;
    kp.row   = 2'd0;
    kp.col   = 2'd0;
    case (code)
      4'd0:    begin kp.row = 2'd3; kp.col = 2'd1; end
      4'd10:   begin kp.row = 2'd3; kp.col = 2'd0; end
      4'd11:   begin kp.row = 2'd3; kp.col = 2'd2; end
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
        kp.row = 2'(m / 4'd3);
        kp.col = 2'(m % 4'd3);
      end
      default: kp.valid = 1'b0;
    endcase
    return kp;
  endfunction

  // Clocks per sine step for each low-group row
  function automatic logic [DIV_W-1:0] row_divider(input logic [1:0] row);
    case (row)
      2'd0:    return DIV_W'(160);
      2'd1:    return DIV_W'(146);
      2'd2:    return DIV_W'(132);
      default: return DIV_W'(118);
    endcase
  endfunction

  // Clocks per sine step for each high-group column
  function automatic logic [DIV_W-1:0] col_divider(input logic [1:0] col);
    case (col)
      2'd0:    return DIV_W'(92);
      2'd1:    return DIV_W'(84);
      default: return DIV_W'(76);
    endcase
  endfunction

  // Quarter-wave magnitude, floor of 7.5*sin(2*pi*j/32)
  function automatic logic [LEVEL_W-1:0] quarter_mag(input logic [3:0] j);
    case (j)
      4'd0:    return LEVEL_W'(0);
      4'd1:    return LEVEL_W'(1);
      4'd2:    return LEVEL_W'(2);
      4'd3:    return LEVEL_W'(4);
      4'd4:    return LEVEL_W'(5);
      4'd5:    return LEVEL_W'(6);
      4'd6:    return LEVEL_W'(6);
      default: return LEVEL_W'(7);
    endcase
  endfunction

  // Offset-binary sine level for a 32-step phase
  function automatic logic [LEVEL_W-1:0] sine_level(input logic [PHASE_W-1:0] p);
    logic [3:0] off;
    logic [3:0] j;
    logic [LEVEL_W-1:0] q;
    off = p[3:0];
    j   = (off > 4'd8) ? 4'(5'd16 - {1'b0, off}) : off;
    q   = quarter_mag(j);
    return p[PHASE_W-1] ? (LEVEL_W'(7) - q) : (LEVEL_W'(8) + q);
  endfunction

  // Weighted combination of the two group levels
  function automatic logic [SAMPLE_W-1:0] mix_sample(input logic [LEVEL_W-1:0] lo,
                                                     input logic [LEVEL_W-1:0] hi,
                                                     input logic [1:0]         sel);
    logic [SAMPLE_W-1:0] lo_part;
    logic [SAMPLE_W-1:0] hi_part;
    lo_part = SAMPLE_W'(LO_WEIGHT) * SAMPLE_W'(lo);
    hi_part = SAMPLE_W'(HI_WEIGHT) * SAMPLE_W'(hi);
    case (sel)
      MIX_LOW:  return lo_part;
      MIX_HIGH: return hi_part;
      default:  return lo_part + hi_part;
    endcase
  endfunction

endpackage

// File: rtl/dtg_tone_osc.sv
module dtg_tone_osc #(
  parameter bit HIGH_GROUP = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         restart,
  input  logic                         run,
  input  logic [1:0]                   sel,
  output logic                         step,
  output logic [dtg_pkg::LEVEL_W-1:0]  level
);
  import dtg_pkg::*;

  logic [DIV_W-1:0]   div;
  logic [DIV_W-1:0]   cnt;
  logic [PHASE_W-1:0] phase;
  logic               wrap;

  generate
    if (HIGH_GROUP) begin : g_high
      assign div = col_divider(sel);
    end else begin : g_low
      assign div = row_divider(sel);
    end
  endgenerate

  assign wrap = (cnt == div - DIV_W'(1));
  assign step = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= '0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= '0;
    end else if (run) begin
      if (wrap) begin
        cnt   <= '0;
        phase <= phase + PHASE_W'(1);
      end else begin
        cnt   <= cnt + DIV_W'(1);
      end
    end
  end

  assign level = sine_level(phase);

endmodule

// File: rtl/dtg_sequencer.sv
module dtg_sequencer #(
  parameter int unsigned TONE_CYC = 311420,
  parameter int unsigned GAP_CYC  = 311420
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic tone_on,
  output logic busy,
  output logic tone_end,
  output logic gap_end
);
  import dtg_pkg::*;

  localparam int unsigned MAX_CYC = (TONE_CYC > GAP_CYC) ? TONE_CYC : GAP_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TONE_LAST = CNT_W'(TONE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign tone_on  = (state == SEQ_TONE);
  assign busy     = (state != SEQ_IDLE);
  assign tone_end = tone_on && (cnt == TONE_LAST);
  assign gap_end  = (state == SEQ_GAP) && (cnt == GAP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (accept) begin
            state <= SEQ_TONE;
            cnt   <= '0;
          end
        end
        SEQ_TONE: begin
          if (tone_end) begin
            state <= SEQ_GAP;
            cnt   <= '0;
          end else begin
            cnt   <= cnt + CNT_W'(1);
          end
        end
        SEQ_GAP: begin
          if (gap_end) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt   <= cnt + CNT_W'(1);
          end
        end
        default: begin
          state <= SEQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dtg_mixer.sv
module dtg_mixer (
  input  logic                          active,
  input  logic [1:0]                    sel,
  input  logic [dtg_pkg::LEVEL_W-1:0]   lo_level,
  input  logic [dtg_pkg::LEVEL_W-1:0]   hi_level,
  output logic [dtg_pkg::SAMPLE_W-1:0]  sample
);
  import dtg_pkg::*;

  always_comb begin
    if (active) sample = mix_sample(lo_level, hi_level, sel);
    else        sample = '0;
  end

endmodule

// File: rtl/dtg_top.sv
module dtg_top #(
  parameter int unsigned TONE_CYC = 311420,
  parameter int unsigned GAP_CYC  = 311420
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [3:0]                    digit,
  input  logic [1:0]                    tone_sel,
  output logic                          busy,
  output logic                          tone_on,
  output logic [dtg_pkg::SAMPLE_W-1:0]  sample
);
  import dtg_pkg::*;

  localparam int GROUPS = 2;

  key_pos_t           key;
  logic               accept;
  logic               tone_end;
  logic               gap_end;
  logic               lo_step;
  logic               hi_step;
  logic [1:0]         row_q;
  logic [1:0]         col_q;
  logic [1:0]         mix_q;
  logic [1:0]         grp_sel [GROUPS];
  logic               grp_step [GROUPS];
  logic [LEVEL_W-1:0] grp_level [GROUPS];

  assign key    = key_lookup(digit);
  assign accept = start && !busy && key.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      mix_q <= MIX_BOTH;
    end else if (accept) begin
      row_q <= key.row;
      col_q <= key.col;
      mix_q <= tone_sel;
    end
  end

  assign grp_sel[0] = row_q;
  assign grp_sel[1] = col_q;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_osc
      dtg_tone_osc #(.HIGH_GROUP(g == 1)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (tone_on),
        .sel     (grp_sel[g]),
        .step    (grp_step[g]),
        .level   (grp_level[g])
      );
    end
  endgenerate

  assign lo_step = grp_step[0];
  assign hi_step = grp_step[1];

  dtg_sequencer #(.TONE_CYC(TONE_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .tone_on  (tone_on),
    .busy     (busy),
    .tone_end (tone_end),
    .gap_end  (gap_end)
  );

  dtg_mixer u_mix (
    .active   (tone_on),
    .sel      (mix_q),
    .lo_level (grp_level[0]),
    .hi_level (grp_level[1]),
    .sample   (sample)
  );

endmodule

// File: rtl/dtg_chk.sv
module dtg_chk #(
  parameter int unsigned TONE_CYC = 311420,
  parameter int unsigned GAP_CYC  = 311420
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [3:0] digit,
  input logic       busy,
  input logic       tone_on,
  input logic [7:0] sample,
  input logic       accept,
  input logic       tone_end,
  input logic       gap_end,
  input logic       lo_step,
  input logic       hi_step
);

  int unsigned tone_cnt;
  int unsigned gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_cnt <= 0;
      gap_cnt  <= 0;
    end else begin
      tone_cnt <= tone_on ? tone_cnt + 1 : 0;
      gap_cnt  <= (busy && !tone_on) ? gap_cnt + 1 : 0;
    end
  end

  // R11
  quiet_outside_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_on |-> (sample == 8'd0));

  // R2
  accept_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && tone_on));

  // R10
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (digit > 4'd11)) |=> !busy);

  // R8
  tone_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tone_on) |-> (tone_cnt == TONE_CYC));

  // R8
  gap_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (gap_cnt == GAP_CYC));

  // R8
  tone_to_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_end |=> (!tone_on && busy));

  // R8
  gap_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_end |=> !busy);

  // R9
  busy_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !gap_end) |=> busy);

  // R4
  step_only_in_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_step || hi_step) |-> tone_on);

endmodule

bind dtg_top dtg_chk #(.TONE_CYC(TONE_CYC), .GAP_CYC(GAP_CYC)) u_dtg_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .digit    (digit),
  .busy     (busy),
  .tone_on  (tone_on),
  .sample   (sample),
  .accept   (accept),
  .tone_end (tone_end),
  .gap_end  (gap_end),
  .lo_step  (lo_step),
  .hi_step  (hi_step)
);

// File: tb/tb_dtg_top.sv
`timescale 1ns/1ps
module tb_dtg_top;

  localparam int TONE_B = 5200;
  localparam int GAP_B  = 300;
  localparam int NVEC   = 15;

  // {digit, tone_sel, row, col}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd1,  2'd0, 2'd0, 2'd0}, {4'd2,  2'd0, 2'd0, 2'd1}, {4'd3,  2'd0, 2'd0, 2'd2},
    {4'd4,  2'd0, 2'd1, 2'd0}, {4'd5,  2'd0, 2'd1, 2'd1}, {4'd6,  2'd0, 2'd1, 2'd2},
    {4'd7,  2'd0, 2'd2, 2'd0}, {4'd8,  2'd0, 2'd2, 2'd1}, {4'd9,  2'd0, 2'd2, 2'd2},
    {4'd10, 2'd0, 2'd3, 2'd0}, {4'd0,  2'd0, 2'd3, 2'd1}, {4'd11, 2'd0, 2'd3, 2'd2},
    {4'd5,  2'd1, 2'd1, 2'd1}, {4'd9,  2'd2, 2'd2, 2'd2}, {4'd3,  2'd3, 2'd0, 2'd2}
  };

  localparam int SINE [32] = '{
    8, 9, 10, 12, 13, 14, 14, 15, 15, 15, 14, 14, 13, 12, 10, 9,
    7, 6, 5, 3, 2, 1, 1, 0, 0, 0, 1, 1, 2, 3, 5, 6
  };
  localparam int LO_DIV [4] = '{160, 146, 132, 118};
  localparam int HI_DIV [4] = '{92, 84, 76, 76};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] digit = 4'd0;
  logic [1:0] tone_sel = 2'd0;
  logic       busy;
  logic       tone_on;
  logic [7:0] sample;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dtg_top #(.TONE_CYC(TONE_B), .GAP_CYC(GAP_B)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .digit(digit),
    .tone_sel(tone_sel), .busy(busy), .tone_on(tone_on), .sample(sample)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int k, input int r, input int c, input int s);
    int lo;
    int hi;
    lo = SINE[(k / LO_DIV[r]) % 32];
    hi = SINE[(k / HI_DIV[c]) % 32];
    if (s == 1) return 4 * lo;
    if (s == 2) return 5 * hi;
    return 4 * lo + 5 * hi;
  endfunction

  task automatic run_burst(input logic [3:0] d, input logic [1:0] s,
                           input int r, input int c, input bit disturb);
    int wave_bad = 0;
    int len_bad  = 0;
    int gap_bad  = 0;
    int got_w    = 0;
    int exp_w    = 0;
    int e;
    digit = d; tone_sel = s; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    // R2: accepted strobe raises busy and tone_on
    check(busy && tone_on, "R2 start accepted", {busy, tone_on}, 3);
    for (int k = 0; k < TONE_B; k++) begin
      e = model(k, r, c, s);
      if (int'(sample) != e) begin
        if (wave_bad == 0) begin got_w = sample; exp_w = e; end
        wave_bad++;
      end
      if (!tone_on || !busy) len_bad++;
      if (disturb && k == 40) begin start = 1'b1; digit = 4'd11; tone_sel = 2'd1; end
      else if (disturb && k == 41) start = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    // R3 R4 R5 R6 R7 R12: every tone cycle matches the model
    check(wave_bad == 0, "R3 R4 R5 R6 R7 R12 waveform", got_w, exp_w);
    // R8: tone ends after exactly TONE_CYC cycles
    check(len_bad == 0 && !tone_on && busy, "R8 tone length", len_bad, 0);
    for (int k = 0; k < GAP_B; k++) begin
      if (!busy || tone_on || sample != 8'd0) gap_bad++;
      if (disturb && k == 3) begin start = 1'b1; digit = 4'd1; end
      else if (disturb && k == 4) start = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    // R11 R9: gap is silent and not restarted
    check(gap_bad == 0, "R11 R9 gap silent", gap_bad, 0);
    // R8: busy clears after exactly GAP_CYC cycles
    check(!busy && !tone_on, "R8 busy clears", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !tone_on && sample == 8'd0, "R1 reset state", {busy, tone_on}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_burst(VEC[i][9:6], VEC[i][5:4], int'(VEC[i][3:2]), int'(VEC[i][1:0]), 1'b0);
    end

    // R9 R12: strobes and input changes during a burst
    run_burst(4'd8, 2'd0, 2, 1, 1'b1);

    // R10: invalid codes
    for (int code = 12; code < 16; code++) begin
      digit = 4'(code); start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      check(!busy && !tone_on && sample == 8'd0, "R10 invalid code ignored", busy, 0);
    end

    // R1: reset in the middle of a tone
    digit = 4'd6; tone_sel = 2'd0; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy && !tone_on && sample == 8'd0, "R1 reset mid-tone", {busy, tone_on}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5: a burst after reset starts from phase zero
    run_burst(4'd0, 2'd0, 3, 1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule